// File: doc/BRIEF.md
# Indexed Host Register Port with Packet Buffer Pointers

This block is the processor-facing side of a network controller. The host bus exposes only two locations. An address write (`cmd` low) loads a register index. A data access (`cmd` high) then reads or writes whatever that index names. A few indices are not plain storage. They stream bytes in and out of an internal packet buffer through pointers that the block advances by itself. The host therefore never handles buffer addresses during a transfer.

The packet buffer is split into two equal halves, each holding 2^PTR_W bytes. The lower half is the transmit area. The host fills it, and the network side reads it through `net_tx_addr` / `net_tx_data`. The upper half is the receive area. The network side fills it through `net_rx_we`, and the host drains it. Each pointer is an offset inside its own half, so it wraps within that half.

Other behaviour:
- The bus runs 8 or 16 bits wide, chosen by `bus16`.
- The select pin is active low unless `cs_inv` is set.
- Two event inputs set latched status bits, and a mask gates them onto `irq`.

Top module: `host_idx_port`

## Requirements
- R1: A selected write with `cmd`=0 loads `wdata[7:0]` into the index register, and a selected read with `cmd`=0 returns the index in `rdata[7:0]`. A data access (`cmd`=1) acts on the register the index names. Unassigned indices read as zero, and every register read returns zero in `rdata[15:8]`.
- R2: An access counts only when `cs_pin` equals `cs_inv` (active low with `cs_inv`=0, active high with `cs_inv`=1). An access with the pin at the other level changes nothing.
- R3: A data read at index 0xF0 returns the receive byte at the read pointer in `rdata[7:0]` (upper byte zero) in 8-bit mode. In 16-bit mode it returns that byte in `rdata[7:0]` and the next byte in `rdata[15:8]`. The read pointer does not move.
- R4: A data read at index 0xF2 returns the same data as R3. It then advances the read pointer by 1 in 8-bit mode or by 2 in 16-bit mode.
- R5: A data write at index 0xF8 stores `wdata[7:0]` at the transmit pointer. In 16-bit mode it also stores `wdata[15:8]` at the following byte. The transmit pointer then advances by 1 or 2.
- R6: Index 0xFA holds bits [7:0] of the transmit pointer and index 0xFB holds the bits above. Indices 0xF4 and 0xF5 do the same for the read pointer. All four are readable and writable.
- R7: Indices 0xFC (low byte) and 0xFD (high byte) hold a 16-bit transmit length, which is driven on `tx_len`.
- R8: Status index 0xFE has two bits. Bit 0 is set by a pulse on `evt_rx_done` and bit 1 by a pulse on `evt_tx_done`. Writing 1 to a bit clears it, but a set in the same cycle wins.
- R9: Mask index 0xFF uses bit 0 to enable the receive event and bit 1 to enable the transmit event. `irq` is high exactly when some status bit and its mask bit are both 1.
- R10: Both pointers wrap modulo 2^PTR_W within their own half. A 16-bit access at the last offset pairs it with offset 0.
- R11: `rdata` changes only on the clock edge that takes a selected read, and holds its value otherwise.
- R12: After reset the following are all zero: index, pointers, length, status, mask, `rdata` and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_pin | input | 1 | Chip select pin |
| cs_inv | input | 1 | 1 makes chip select active high |
| bus16 | input | 1 | 1 selects the 16-bit data mode |
| cmd | input | 1 | 0 = index location, 1 = data location |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Registered host read data |
| irq | output | 1 | Interrupt request |
| tx_len | output | 16 | Transmit length register |
| net_rx_we | input | 1 | Network side writes a receive byte |
| net_rx_addr | input | PTR_W | Receive area offset for that write |
| net_rx_data | input | 8 | Receive byte |
| net_tx_addr | input | PTR_W | Transmit area offset read by the network side |
| net_tx_data | output | 8 | Transmit byte at that offset |
| evt_rx_done | input | 1 | Packet received event pulse |
| evt_tx_done | input | 1 | Packet transmitted event pulse |

## Verification
The receive stream is read with several patterns, in both bus widths:
- Repeated peeks at one place show that 0xF0 leaves the pointer alone.
- Back-to-back streaming reads show the step of 1 versus 2.
- A 16-bit read that follows a peek shows that the prefetched word and the direct word agree.

The transmit stream is written in 8-bit and 16-bit mode. The bytes are then read back on the network side, which separates byte order from pointer step. Accesses at the last offset of each half show whether the wrap stays inside that half. The interrupt pattern raises events under a closed and then an open mask, clears them by writing 1, and collides a clear with a new event.

// File: rtl/host_idx_port.sv
module host_idx_port #(
  parameter int PTR_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_pin,
  input  logic             cs_inv,
  input  logic             bus16,
  input  logic             cmd,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [15:0]      wdata,
  output logic [15:0]      rdata,
  output logic             irq,
  output logic [15:0]      tx_len,
  input  logic             net_rx_we,
  input  logic [PTR_W-1:0] net_rx_addr,
  input  logic [7:0]       net_rx_data,
  input  logic [PTR_W-1:0] net_tx_addr,
  output logic [7:0]       net_tx_data,
  input  logic             evt_rx_done,
  input  logic             evt_tx_done
);
  localparam int REGION = 1 << PTR_W;
  localparam int MEM_N  = 2 * REGION;
  localparam int HI_W   = PTR_W - 8;
  localparam logic [7:0] IX_PEEK = 8'hF0, IX_STRM = 8'hF2, IX_RPL = 8'hF4, IX_RPH = 8'hF5;
  localparam logic [7:0] IX_WDAT = 8'hF8, IX_WPL = 8'hFA, IX_WPH = 8'hFB;
  localparam logic [7:0] IX_LNL = 8'hFC, IX_LNH = 8'hFD, IX_ISR = 8'hFE, IX_IMR = 8'hFF;

  logic [7:0]       mem [MEM_N];
  logic [7:0]       idx;
  logic [PTR_W-1:0] rd_ptr, tx_ptr;
  logic [15:0]      len_q;
  logic [1:0]       isr, imr;
  logic [15:0]      pf_q;
  logic             pf_ok;
  logic [15:0]      reg_val;

  wire sel   = (cs_pin == cs_inv);
  wire rd_go = sel & rd_en;
  wire wr_go = sel & wr_en;
  wire d_rd  = rd_go & cmd;
  wire d_wr  = wr_go & cmd;

  wire [PTR_W-1:0] step = bus16 ? PTR_W'(2) : PTR_W'(1);
  wire [PTR_W-1:0] rp1  = rd_ptr + PTR_W'(1);
  wire [PTR_W-1:0] tp1  = tx_ptr + PTR_W'(1);
  wire [7:0]  rx_lo   = mem[{1'b1, rd_ptr}];
  wire [7:0]  rx_hi   = mem[{1'b1, rp1}];
  wire [15:0] rx_word = bus16 ? {rx_hi, rx_lo} : {8'h00, rx_lo};
  wire [15:0] pf_word = bus16 ? pf_q : {8'h00, pf_q[7:0]};

  wire tx_we   = d_wr && idx == IX_WDAT;
  wire rp_wr   = d_wr && (idx == IX_RPL || idx == IX_RPH);
  wire isr_clr = d_wr && idx == IX_ISR;

  assign irq         = |(isr & imr);
  assign tx_len      = len_q;
  assign net_tx_data = mem[{1'b0, net_tx_addr}];

  always_comb begin
    case (idx)
      IX_PEEK: reg_val = rx_word;
      IX_STRM: reg_val = pf_ok ? pf_word : rx_word;
      IX_RPL:  reg_val = {8'h00, rd_ptr[7:0]};
      IX_RPH:  reg_val = {8'h00, 8'(rd_ptr >> 8)};
      IX_WPL:  reg_val = {8'h00, tx_ptr[7:0]};
      IX_WPH:  reg_val = {8'h00, 8'(tx_ptr >> 8)};
      IX_LNL:  reg_val = {8'h00, len_q[7:0]};
      IX_LNH:  reg_val = {8'h00, len_q[15:8]};
      IX_ISR:  reg_val = {14'h0, isr};
      IX_IMR:  reg_val = {14'h0, imr};
      default: reg_val = 16'h0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= 8'h00;
      rd_ptr <= '0;
      tx_ptr <= '0;
      len_q  <= 16'h0000;
      isr    <= 2'b00;
      imr    <= 2'b00;
      rdata  <= 16'h0000;
      pf_q   <= 16'h0000;
      pf_ok  <= 1'b0;
    end else begin
      if (wr_go && !cmd) idx <= wdata[7:0];
      if (rd_go) rdata <= cmd ? reg_val : {8'h00, idx};

      if (d_rd && idx == IX_PEEK) begin
        pf_q  <= {rx_hi, rx_lo};
        pf_ok <= 1'b1;
      end
      if (d_rd && idx == IX_STRM) begin
        rd_ptr <= rd_ptr + step;
        pf_ok  <= 1'b0;
      end
      if (rp_wr) begin
        pf_ok <= 1'b0;
        if (idx == IX_RPL) rd_ptr <= {rd_ptr[PTR_W-1:8], wdata[7:0]};
        else               rd_ptr <= {wdata[HI_W-1:0], rd_ptr[7:0]};
      end
      if (net_rx_we) pf_ok <= 1'b0;

      if (tx_we) tx_ptr <= tx_ptr + step;
      if (d_wr && idx == IX_WPL) tx_ptr <= {tx_ptr[PTR_W-1:8], wdata[7:0]};
      if (d_wr && idx == IX_WPH) tx_ptr <= {wdata[HI_W-1:0], tx_ptr[7:0]};
      if (d_wr && idx == IX_LNL) len_q[7:0]  <= wdata[7:0];
      if (d_wr && idx == IX_LNH) len_q[15:8] <= wdata[7:0];
      if (d_wr && idx == IX_IMR) imr <= wdata[1:0];

      isr <= (isr & ~(isr_clr ? wdata[1:0] : 2'b00)) | {evt_tx_done, evt_rx_done};
    end
  end

  always_ff @(posedge clk) begin
    if (tx_we) begin
      mem[{1'b0, tx_ptr}] <= wdata[7:0];
      if (bus16) mem[{1'b0, tp1}] <= wdata[15:8];
    end
    if (net_rx_we) mem[{1'b1, net_rx_addr}] <= net_rx_data;
  end
endmodule

// File: rtl/host_idx_port_chk.sv
module host_idx_port_chk #(
  parameter int PTR_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_pin,
  input logic             cs_inv,
  input logic             bus16,
  input logic             cmd,
  input logic             rd_en,
  input logic             wr_en,
  input logic [15:0]      wdata,
  input logic             evt_rx_done,
  input logic             irq,
  input logic [15:0]      rdata,
  input logic [7:0]       idx,
  input logic [PTR_W-1:0] rd_ptr,
  input logic [PTR_W-1:0] tx_ptr,
  input logic [1:0]       imr,
  input logic [1:0]       isr
);
  wire sel = (cs_pin == cs_inv);

  assert_cs_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> ($stable(idx) && $stable(imr) && $stable(tx_ptr) && $stable(rd_ptr)));

  assert_peek_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && rd_en && !wr_en && cmd && idx == 8'hF0) |=> $stable(rd_ptr));

  assert_stream_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && rd_en && !wr_en && cmd && idx == 8'hF2) |=>
      rd_ptr == PTR_W'($past(rd_ptr) + ($past(bus16) ? 2 : 1)));

  assert_tx_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && cmd && idx == 8'hF8) |=>
      tx_ptr == PTR_W'($past(tx_ptr) + ($past(bus16) ? 2 : 1)));

  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && cmd && idx == 8'hFE && wdata[0] && !evt_rx_done) |=> !isr[0]);

  assert_irq_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (imr == 2'b00) |-> !irq);

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && rd_en) |=> $stable(rdata));
endmodule

bind host_idx_port host_idx_port_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_pin(cs_pin), .cs_inv(cs_inv), .bus16(bus16),
  .cmd(cmd), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
  .evt_rx_done(evt_rx_done), .irq(irq), .rdata(rdata), .idx(idx),
  .rd_ptr(rd_ptr), .tx_ptr(tx_ptr), .imr(imr), .isr(isr)
);

// File: tb/tb_host_idx_port.sv
module tb_host_idx_port;
  localparam int PTR_W = 9;
  logic clk = 0, rst_n = 0;
  logic cs_pin = 1, cs_inv = 0, bus16 = 0, cmd = 0, rd_en = 0, wr_en = 0;
  logic [15:0] wdata = 0, rdata, tx_len;
  logic irq;
  logic net_rx_we = 0;
  logic [PTR_W-1:0] net_rx_addr = 0, net_tx_addr = 0;
  logic [7:0] net_rx_data = 0, net_tx_data;
  logic evt_rx_done = 0, evt_tx_done = 0;
  int checks = 0, errors = 0;
  logic [15:0] q;

  always #10 clk = ~clk;

  host_idx_port #(.PTR_W(PTR_W)) dut (.*);

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic c, input logic [15:0] d, input logic act = 1'b1);
    cs_pin = act ? cs_inv : ~cs_inv; cmd = c; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0; cs_pin = ~cs_inv;
  endtask

  task automatic bus_rd(input logic c, output logic [15:0] r);
    cs_pin = cs_inv; cmd = c; rd_en = 1;
    @(negedge clk);
    rd_en = 0; cs_pin = ~cs_inv; r = rdata;
  endtask

  task automatic reg_wr(input logic [7:0] ix, input logic [15:0] v);
    bus_wr(0, {8'h00, ix}); bus_wr(1, v);
  endtask

  task automatic reg_rd(input logic [7:0] ix, output logic [15:0] r);
    bus_wr(0, {8'h00, ix}); bus_rd(1, r);
  endtask

  task automatic net_fill(input int off, input logic [7:0] b);
    net_rx_we = 1; net_rx_addr = PTR_W'(off); net_rx_data = b;
    @(negedge clk);
    net_rx_we = 0;
  endtask

  task automatic t_reset;
    chk("R12 rdata", rdata, 16'h0);
    chk("R12 irq", {15'h0, irq}, 16'h0);
    chk("R12 tx_len", tx_len, 16'h0);
    reg_rd(8'hF4, q); chk("R12 read ptr", q, 16'h0);
  endtask

  task automatic t_index;
    reg_wr(8'hFF, 16'h0003);
    bus_rd(0, q); chk("R1 index readback", q, 16'h00FF);
    bus_rd(1, q); chk("R1 data via index", q, 16'h0003);
    reg_rd(8'h20, q); chk("R1 unassigned index", q, 16'h0000);
  endtask

  task automatic t_cs;
    bus_wr(0, 16'h00FF); bus_wr(1, 16'h0000, 1'b0);
    bus_rd(1, q); chk("R2 inactive select ignored", q, 16'h0003);
    cs_inv = 1; cs_pin = 0;
    @(negedge clk);
    reg_wr(8'hFF, 16'h0001);
    reg_rd(8'hFF, q); chk("R2 inverted select", q, 16'h0001);
    cs_inv = 0; cs_pin = 1;
    @(negedge clk);
  endtask

  task automatic t_rx_read;
    for (int i = 0; i < 16; i++) net_fill(i, 8'hA0 + 8'(i));
    net_fill(511, 8'h5C);
    bus16 = 0;
    reg_wr(8'hF4, 16'h0); reg_wr(8'hF5, 16'h0);
    bus_wr(0, 16'h00F0);
    bus_rd(1, q); chk("R3 peek 8-bit", q, 16'h00A0);
    bus_rd(1, q); chk("R3 peek does not advance", q, 16'h00A0);
    bus_wr(0, 16'h00F2);
    bus_rd(1, q); chk("R4 stream 8-bit first", q, 16'h00A0);
    bus_rd(1, q); chk("R4 stream 8-bit step 1", q, 16'h00A1);
    bus16 = 1;
    bus_wr(0, 16'h00F0);
    bus_rd(1, q); chk("R3 peek 16-bit", q, 16'hA3A2);
    bus_wr(0, 16'h00F2);
    bus_rd(1, q); chk("R4 stream 16-bit after peek", q, 16'hA3A2);
    bus_rd(1, q); chk("R4 stream 16-bit step 2", q, 16'hA5A4);
    reg_rd(8'hF4, q); chk("R6 read ptr low", q, 16'h0006);
    reg_wr(8'hF4, 16'h00FF); reg_wr(8'hF5, 16'h0001);
    reg_rd(8'hF2, q); chk("R10 rx wrap pair", q, 16'hA05C);
    reg_rd(8'hF4, q); chk("R10 rx ptr wrapped low", q, 16'h0001);
    reg_rd(8'hF5, q); chk("R10 rx ptr wrapped high", q, 16'h0000);
  endtask

  task automatic tx_byte(input int off, input logic [7:0] exp, input string tag);
    net_tx_addr = PTR_W'(off);
    #1 chk(tag, {8'h00, net_tx_data}, {8'h00, exp});
  endtask

  task automatic t_tx_write;
    bus16 = 0;
    reg_wr(8'hFA, 16'h0010); reg_wr(8'hFB, 16'h0000);
    bus_wr(0, 16'h00F8); bus_wr(1, 16'h0011); bus_wr(1, 16'h0022);
    tx_byte(16'h10, 8'h11, "R5 8-bit byte 0");
    tx_byte(16'h11, 8'h22, "R5 8-bit byte 1");
    reg_rd(8'hFA, q); chk("R5 8-bit step", q, 16'h0012);
    bus16 = 1;
    reg_wr(8'hF8, 16'h4433);
    tx_byte(16'h12, 8'h33, "R5 16-bit low byte");
    tx_byte(16'h13, 8'h44, "R5 16-bit high byte");
    reg_rd(8'hFA, q); chk("R5 16-bit step", q, 16'h0014);
    reg_wr(8'hFA, 16'h00FF); reg_wr(8'hFB, 16'h0001);
    reg_rd(8'hFB, q); chk("R6 tx ptr high", q, 16'h0001);
    reg_wr(8'hF8, 16'h6655);
    tx_byte(511, 8'h55, "R10 tx last offset");
    tx_byte(0, 8'h66, "R10 tx wrapped byte");
    reg_rd(8'hFA, q); chk("R10 tx ptr low", q, 16'h0001);
    reg_rd(8'hFB, q); chk("R10 tx ptr high", q, 16'h0000);
    bus16 = 0;
  endtask

  task automatic t_len;
    reg_wr(8'hFC, 16'h0034); reg_wr(8'hFD, 16'h0012);
    chk("R7 tx_len", tx_len, 16'h1234);
    reg_rd(8'hFD, q); chk("R7 length high read", q, 16'h0012);
  endtask

  task automatic t_irq;
    reg_wr(8'hFF, 16'h0000);
    evt_rx_done = 1; @(negedge clk); evt_rx_done = 0;
    chk("R9 masked irq low", {15'h0, irq}, 16'h0);
    reg_rd(8'hFE, q); chk("R8 rx status set", q, 16'h0001);
    reg_wr(8'hFF, 16'h0001);
    chk("R11 rdata held", rdata, 16'h0001);
    chk("R9 irq on enable", {15'h0, irq}, 16'h1);
    reg_wr(8'hFE, 16'h0001);
    chk("R8 write one clears", {15'h0, irq}, 16'h0);
    evt_tx_done = 1; @(negedge clk); evt_tx_done = 0;
    reg_wr(8'hFF, 16'h0003);
    chk("R9 tx irq", {15'h0, irq}, 16'h1);
    bus_wr(0, 16'h00FE);
    evt_tx_done = 1; bus_wr(1, 16'h0002); evt_tx_done = 0;
    reg_rd(8'hFE, q); chk("R8 set wins over clear", q, 16'h0002);
    reg_wr(8'hFE, 16'h0002);
    reg_rd(8'hFE, q); chk("R8 tx cleared", q, 16'h0000);
    chk("R9 irq low after clear", {15'h0, irq}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_index;
    t_cs;
    t_rx_read;
    t_tx_write;
    t_len;
    t_irq;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule